// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block produces an active-low processor reset from a single digital "supply is good" indication, such as the output of a comparator that has been brought into the clock domain. While the indication is low, reset stays asserted. When the indication becomes good, reset is held for a configurable number of clock cycles and then released. After release, the block filters short dips: a dip must outlast a configurable number of cycles before it counts. A dip that counts starts a reset pulse of fixed length. If the level is still bad when that pulse ends, reset stays low until the level recovers and a new full period has elapsed.

All timing is in clock cycles. The indication passes through a two-stage synchronizer inside the block. The period and glitch-limit inputs are captured when their counts start, so software or straps may change them at any time without disturbing a count in progress. A one-cycle status strobe marks the start of each new reset period.

Top module: `supv_reset_pulse`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `rst_n_o` and `period_start_o` are 0.
- R2: While the synchronized level is low and reset has not been released, `rst_n_o` stays 0 for any length of time.
- R3: From the hold state, when `lvl_ok_i` rises before a clock edge counted as edge 1, `rst_n_o` rises exactly at edge P+3, where P is `period_cfg_i` and a value of 0 acts as 1. The three extra edges are two synchronizer stages and one decision cycle.
- R4: If the level drops during the qualifying period, the count is abandoned and reset stays low. Release then waits for a full period that starts after the level becomes good again.
- R5: After release, a dip of `lvl_ok_i` that lasts at most G rising edges leaves `rst_n_o` at 1. G is `glitch_cfg_i`, and a value of 0 acts as 1.
- R6: After release, a dip lasting G+1 or more edges drives `rst_n_o` to 0 at edge G+3, counting from the first edge at which the input is low.
- R7: A triggered reset lasts exactly P cycles whatever the level does meanwhile. If the level is good when it ends, `rst_n_o` returns to 1.
- R8: If the level is still low when a triggered reset ends, `rst_n_o` stays 0 until the level recovers, and then follows R3.
- R9: `period_start_o` is high for exactly one cycle each time a reset period starts, and only while `rst_n_o` is 0. For a qualifying period this is edge 3. For a triggered period it is the same edge at which `rst_n_o` falls.
- R10: `period_cfg_i` is captured when a period starts. Changing it during the count does not change the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| lvl_ok_i | input | 1 | Monitored level above threshold (asynchronous) |
| period_cfg_i | input | PER_W | Reset period in cycles |
| glitch_cfg_i | input | GLT_W | Longest ignored dip in cycles |
| rst_n_o | output | 1 | Active-low reset output, registered |
| period_start_o | output | 1 | One-cycle strobe when a reset period begins |

## Verification
A table of dip lengths is applied from the released state. Each entry sits on one side of the glitch limit: either exactly at the limit or one cycle past it, with limits of 0, 1 and larger values. This separates an ignored dip from a triggering one. It also confirms the exact edge at which reset falls and how long the fixed pulse lasts, including a pulse of one cycle. Directed sequences cover several further cases:
- a level that stays low through the end of a triggered pulse;
- a level that drops partway through the qualifying period, which must restart the count;
- a period setting changed in the middle of a count;
- a period setting of 0.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,   // level bad, reset held, no count
    ST_QUAL,   // level good, counting period before release
    ST_RUN,    // released
    ST_FILT,   // released, level dipped, measuring dip
    ST_TRIG    // fixed-length reset after a qualifying dip
  } supv_state_t;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R7: an expired timer stays expired until reloaded (no wrap)
  a_r7_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/supv_reset_pulse.sv
module supv_reset_pulse
  import supv_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int GLT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_ok_i,
  input  logic [PER_W-1:0] period_cfg_i,
  input  logic [GLT_W-1:0] glitch_cfg_i,
  output logic             rst_n_o,
  output logic             period_start_o
);
  localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);
  localparam logic [GLT_W-1:0] GLT_ONE = GLT_W'(1);

  logic ok_s;
  supv_state_t st, nxt;
  logic ld_per, ld_glt, per_zero, glt_zero;
  logic [PER_W-1:0] per_val;
  logic [GLT_W-1:0] glt_val;

  supv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(lvl_ok_i), .q(ok_s)
  );

  // a setting of 0 behaves as 1: load one less than the cycle count
  assign per_val = (period_cfg_i == '0) ? '0 : period_cfg_i - PER_ONE;
  assign glt_val = (glitch_cfg_i == '0) ? '0 : glitch_cfg_i - GLT_ONE;

  supv_timer #(.W(PER_W)) i_per_tmr (
    .clk(clk), .rst(rst), .load(ld_per), .load_val(per_val), .zero(per_zero)
  );

  supv_timer #(.W(GLT_W)) i_glt_tmr (
    .clk(clk), .rst(rst), .load(ld_glt), .load_val(glt_val), .zero(glt_zero)
  );

  always_comb begin
    nxt    = st;
    ld_per = 1'b0;
    ld_glt = 1'b0;
    unique case (st)
      ST_HOLD: if (ok_s) begin nxt = ST_QUAL; ld_per = 1'b1; end
      ST_QUAL: begin
        if (!ok_s)         nxt = ST_HOLD;
        else if (per_zero) nxt = ST_RUN;
      end
      ST_RUN:  if (!ok_s) begin nxt = ST_FILT; ld_glt = 1'b1; end
      ST_FILT: begin
        if (ok_s)          nxt = ST_RUN;
        else if (glt_zero) begin nxt = ST_TRIG; ld_per = 1'b1; end
      end
      ST_TRIG: if (per_zero) nxt = ok_s ? ST_RUN : ST_HOLD;
      default: nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_HOLD;
      rst_n_o        <= 1'b0;
      period_start_o <= 1'b0;
    end else begin
      st             <= nxt;
      rst_n_o        <= (nxt == ST_RUN) || (nxt == ST_FILT);
      period_start_o <= ld_per;
    end
  end

  // R1: clear forces both outputs low on the following cycle
  a_r1_clear_outputs: assert property (@(posedge clk)
    rst |=> (!rst_n_o && !period_start_o));

  // R2: a held reset with a bad level stays held
  a_r2_low_keeps_reset: assert property (@(posedge clk) disable iff (rst)
    (!rst_n_o && !ok_s) |=> !rst_n_o);

  // R3: release only follows a good synchronized level
  a_r3_release_needs_ok: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(ok_s));

  // R6: every fall of reset after release starts a new period
  a_r6_fall_starts_period: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> period_start_o);

  // R9: strobe lasts one cycle and only while reset is asserted
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
    period_start_o |=> !period_start_o);
  a_r9_strobe_in_reset: assert property (@(posedge clk) disable iff (rst)
    period_start_o |-> !rst_n_o);
endmodule

// File: tb/test_supv_reset_pulse.sv
module test_supv_reset_pulse;
  logic       clk = 1'b0;
  logic       rst;
  logic       lvl_ok_i;
  logic [15:0] period_cfg_i;
  logic [7:0]  glitch_cfg_i;
  logic       rst_n_o;
  logic       period_start_o;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;   // 50 MHz

  supv_reset_pulse i_supv_reset_pulse (
    .clk(clk), .rst(rst), .lvl_ok_i(lvl_ok_i),
    .period_cfg_i(period_cfg_i), .glitch_cfg_i(glitch_cfg_i),
    .rst_n_o(rst_n_o), .period_start_o(period_start_o)
  );

  // {period, glitch limit, dip length}
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{4, 3, 3}, '{4, 3, 4}, '{5, 1, 1}, '{5, 1, 2}, '{3, 0, 1},
    '{3, 0, 2}, '{6, 5, 5}, '{6, 5, 6}, '{1, 2, 3}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // From hold: raise level; rst_n rises at edge pm+3, strobe at edge 3
  task automatic qualify(int p, int chg_at, int newp, string req);
    int pm;
    pm = (p < 1) ? 1 : p;
    period_cfg_i = 16'(p);
    lvl_ok_i = 1'b1;
    for (int n = 1; n <= pm + 3; n++) begin
      cyc();
      chk(req, int'(rst_n_o), (n >= pm + 3) ? 1 : 0);
      chk("R9", int'(period_start_o), (n == 3) ? 1 : 0);
      if (n == chg_at) period_cfg_i = 16'(newp);
    end
  endtask

  // Drive into the hold state via a long dip (R8 path)
  task automatic to_hold();
    glitch_cfg_i = 8'd1;
    period_cfg_i = 16'd4;
    lvl_ok_i = 1'b0;
    repeat (12) cyc();
    chk("R2", int'(rst_n_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    lvl_ok_i = 1'b1;
    period_cfg_i = 16'd5;
    glitch_cfg_i = 8'd2;
    repeat (3) cyc();
    chk("R1", int'(rst_n_o), 0);
    chk("R1", int'(period_start_o), 0);

    // R2: level low, reset released -> output stays low
    rst = 1'b0;
    lvl_ok_i = 1'b0;
    for (int n = 0; n < 20; n++) begin
      cyc();
      chk("R2", int'(rst_n_o), 0);
    end

    // R3: release after P cycles
    qualify(5, 0, 0, "R3");

    // R5/R6/R7 dip table
    for (int i = 0; i < NV; i++) begin
      int p, g, l, gm;
      bit trig;
      p  = VEC[i][0];
      g  = VEC[i][1];
      l  = VEC[i][2];
      gm = (g < 1) ? 1 : g;
      trig = (l > gm);
      period_cfg_i = 16'(p);
      glitch_cfg_i = 8'(g);
      lvl_ok_i = 1'b0;
      for (int n = 1; n <= gm + p + 6; n++) begin
        cyc();
        if (n == l) lvl_ok_i = 1'b1;
        if (trig) begin
          chk("R6 R7", int'(rst_n_o), (n >= gm + 3 && n <= gm + 2 + p) ? 0 : 1);
          chk("R9", int'(period_start_o), (n == gm + 3) ? 1 : 0);
        end else begin
          chk("R5", int'(rst_n_o), 1);
          chk("R9", int'(period_start_o), 0);
        end
      end
    end

    // R8: level stays low past the triggered pulse
    period_cfg_i = 16'd4;
    glitch_cfg_i = 8'd2;
    lvl_ok_i = 1'b0;
    for (int n = 1; n <= 30; n++) begin
      cyc();
      chk("R8", int'(rst_n_o), (n < 5) ? 1 : 0);
    end
    qualify(4, 0, 0, "R8");

    // R4: drop during qualification restarts the count
    to_hold();
    period_cfg_i = 16'd10;
    lvl_ok_i = 1'b1;
    for (int n = 0; n < 5; n++) begin
      cyc();
      chk("R4", int'(rst_n_o), 0);
    end
    lvl_ok_i = 1'b0;
    for (int n = 0; n < 2; n++) begin
      cyc();
      chk("R4", int'(rst_n_o), 0);
    end
    qualify(10, 0, 0, "R4");

    // R10: period change mid-count is ignored
    to_hold();
    qualify(8, 3, 2, "R10");

    // R3: period 0 acts as 1
    to_hold();
    qualify(0, 0, 0, "R3");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule